// File: doc/BRIEF.md
# Segmented Carry-Save Add-Reduce Tree

This block adds a build-time number of equal-width operands in one pass. It reduces them through rows of full adders, where each row turns every group of three operands into a sum word and a shifted carry word. The last two words then go through a carry-propagate adder. Two run-time enables can break the carry chain, one at bit 4 and one at bit 8. The 16-bit word is then treated as two or three independent fields, each summed modulo its own width, so several narrow reductions run side by side in the same hardware.

The reduction has one slot per full-adder row and one final slot for the carry-propagate adder. Each slot can receive a pipeline register, chosen at build time with a bit mask. The enables travel with their operands through every register, so a new operand set and a new segmentation can be applied on every clock. If the mask marks a slot that the tree does not have for the chosen operand count, elaboration stops with an error.

Top module: `seg_add_tree`

## Requirements
- R1: Operand i sits at bits [i*16 +: 16] of `opsIn`, and every one of the `NUM_INPUTS` operands contributes to the result with equal weight.
- R2: With `partEn` = 2'b00, `sumOut` is the sum of all operands modulo 2^16.
- R3: `partEn[0]` = 1 stops the carry from bit 3 into bit 4, and `partEn[1]` = 1 stops the carry from bit 7 into bit 8. Each resulting field of `sumOut` equals the sum of the same field of every operand, modulo 2 to the power of the field width.
- R4: The latency from `opsIn`/`partEn` to `sumOut` equals the number of set bits of `REG_LEVELS` among the slots 0..D. Slot k < D is full-adder row k, and slot D is the final adder, where D is the tree depth. A new operand set and segmentation is accepted on every cycle, and with no registered slot the output is combinational.
- R5: When built with zero operands, `sumOut` is always zero.
- R6: While `rstN` is low, every pipeline register holds zero, so `sumOut` is zero whenever the final slot is registered.
- R7: While `opsIn` and `partEn` stay unchanged, `sumOut` stays unchanged once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| rstN | input | 1 | Asynchronous active-low reset |
| opsIn | input | max(NUM_INPUTS,1)*WIDTH | Packed operands, operand 0 in the lowest bits |
| partEn | input | 2 | Carry-break enables: bit 0 at bit 4, bit 1 at bit 8 |
| sumOut | output | WIDTH | Segmented sum of the operands |

## Verification
Three configurations are tested: nine operands with three registered slots, two operands with no register, and zero operands with a registered final adder. Operand sets in which every operand is all ones, 0x000F or 0x00FF drive carries straight into each break point. These show whether a break drops exactly one carry per operand pair or leaks one into the next field. Walking-one and single-operand vectors show whether each operand lands at the right slice and weight. Long pseudo-random runs change the segmentation on every cycle, which shows whether the enables stay aligned with their data through the registered slots. Held vectors test output stability.

// File: rtl/seg_add_pkg.sv
package seg_add_pkg;

  localparam int MASK_BITS = 8;

  typedef struct packed {
    logic cutLo;
    logic cutHi;
  } segCtrl_t;

  function automatic int nextCount(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int countAt(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = nextCount(c);
    return c;
  endfunction

  function automatic int treeDepth(input int n);
    int c;
    int d;
    c = n;
    d = 0;
    while (c > 2) begin
      c = nextCount(c);
      d++;
    end
    return d;
  endfunction

  function automatic int regCount(input logic [MASK_BITS-1:0] mask, input int lastSlot);
    int s;
    s = 0;
    for (int i = 0; i < MASK_BITS; i++)
      if (i <= lastSlot && mask[i]) s++;
    return s;
  endfunction

  function automatic logic carryPass(input int bitPos, input segCtrl_t c,
                                     input int lo, input int hi);
    return !((c.cutLo && bitPos == lo) || (c.cutHi && bitPos == hi));
  endfunction

endpackage

// File: rtl/seg_add_ctrl.sv
module seg_add_ctrl import seg_add_pkg::*; (
  input  logic [1:0] partEn,
  output segCtrl_t   segCtrl
);
  assign segCtrl.cutLo = partEn[0];
  assign segCtrl.cutHi = partEn[1];
endmodule

// File: rtl/seg_csa_row.sv
module seg_csa_row import seg_add_pkg::*; #(
  parameter int WIDTH  = 16,
  parameter int IN_CNT = 3,
  parameter int CUT_LO = 4,
  parameter int CUT_HI = 8,
  localparam int GROUPS  = IN_CNT / 3,
  localparam int REST    = IN_CNT % 3,
  localparam int OUT_CNT = 2 * GROUPS + REST
) (
  input  logic [IN_CNT-1:0][WIDTH-1:0]  opsIn,
  input  segCtrl_t                      segCtrl,
  output logic [OUT_CNT-1:0][WIDTH-1:0] opsOut
);
  always_comb begin
    logic [WIDTH-1:0] a, b, c;
    opsOut = '0;
    for (int g = 0; g < GROUPS; g++) begin
      a = opsIn[3*g];
      b = opsIn[3*g+1];
      c = opsIn[3*g+2];
      opsOut[2*g] = a ^ b ^ c;
      for (int bt = 1; bt < WIDTH; bt++)
        opsOut[2*g+1][bt] = carryPass(bt, segCtrl, CUT_LO, CUT_HI) &
          ((a[bt-1] & b[bt-1]) | (a[bt-1] & c[bt-1]) | (b[bt-1] & c[bt-1]));
    end
    for (int r = 0; r < REST; r++)
      opsOut[2*GROUPS+r] = opsIn[3*GROUPS+r];
  end
endmodule

// File: rtl/seg_part_add.sv
module seg_part_add import seg_add_pkg::*; #(
  parameter int WIDTH  = 16,
  parameter int CUT_LO = 4,
  parameter int CUT_HI = 8
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  segCtrl_t         segCtrl,
  output logic [WIDTH-1:0] addSum
);
  always_comb begin
    logic cy;
    cy = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      addSum[i] = addA[i] ^ addB[i] ^ cy;
      cy = carryPass(i + 1, segCtrl, CUT_LO, CUT_HI) &
           ((addA[i] & addB[i]) | (addA[i] & cy) | (addB[i] & cy));
    end
  end
endmodule

// File: rtl/seg_add_datapath.sv
module seg_add_datapath import seg_add_pkg::*; #(
  parameter int WIDTH      = 16,
  parameter int NUM_INPUTS = 9,
  parameter logic [MASK_BITS-1:0] REG_LEVELS = 8'h15,
  parameter int CUT_LO     = 4,
  parameter int CUT_HI     = 8,
  localparam int OP_BITS = ((NUM_INPUTS > 0) ? NUM_INPUTS : 1) * WIDTH,
  localparam int OPS     = (NUM_INPUTS < 2) ? 2 : NUM_INPUTS,
  localparam int NLEV    = treeDepth(OPS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OP_BITS-1:0] opsIn,
  input  segCtrl_t           segCtrl,
  output logic [WIDTH-1:0]   sumOut
);
  if ((REG_LEVELS >> (NLEV + 1)) != 0) begin : g_badLevels
    $error("REG_LEVELS marks a slot beyond the tree depth");
  end

  for (genvar k = 0; k <= NLEV; k++) begin : lvl
    localparam int IN_CNT  = countAt(OPS, k);
    localparam int OUT_CNT = (k < NLEV) ? countAt(OPS, k + 1) : 1;
    logic [IN_CNT-1:0][WIDTH-1:0]  stIn;
    logic [OUT_CNT-1:0][WIDTH-1:0] stComb;
    logic [OUT_CNT-1:0][WIDTH-1:0] stOut;
    segCtrl_t ctlIn;

    if (k == 0) begin : g_src
      for (genvar i = 0; i < OPS; i++) begin : g_pad
        if (i < NUM_INPUTS) begin : g_op
          assign stIn[i] = opsIn[i*WIDTH +: WIDTH];
        end else begin : g_zero
          assign stIn[i] = '0;
        end
      end
      assign ctlIn = segCtrl;
    end else begin : g_chain
      assign stIn  = lvl[k-1].stOut;
      assign ctlIn = lvl[k-1].g_csa.ctlOut;
    end

    if (k < NLEV) begin : g_csa
      segCtrl_t ctlOut;
      seg_csa_row #(.WIDTH(WIDTH), .IN_CNT(IN_CNT), .CUT_LO(CUT_LO), .CUT_HI(CUT_HI))
        row_i (.opsIn(stIn), .segCtrl(ctlIn), .opsOut(stComb));
      if (REG_LEVELS[k]) begin : g_reg
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            stOut  <= '0;
            ctlOut <= '0;
          end else begin
            stOut  <= stComb;
            ctlOut <= ctlIn;
          end
        end
      end else begin : g_wire
        assign stOut  = stComb;
        assign ctlOut = ctlIn;
      end
    end else begin : g_fin
      seg_part_add #(.WIDTH(WIDTH), .CUT_LO(CUT_LO), .CUT_HI(CUT_HI))
        adder_i (.addA(stIn[0]), .addB(stIn[1]), .segCtrl(ctlIn), .addSum(stComb[0]));
      if (REG_LEVELS[k]) begin : g_reg
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stOut <= '0;
          else       stOut <= stComb;
        end
      end else begin : g_wire
        assign stOut = stComb;
      end
    end
  end

  assign sumOut = lvl[NLEV].stOut[0];
endmodule

// File: rtl/seg_add_tree.sv
module seg_add_tree import seg_add_pkg::*; #(
  parameter int WIDTH      = 16,
  parameter int NUM_INPUTS = 9,
  parameter logic [MASK_BITS-1:0] REG_LEVELS = 8'h15,
  parameter int CUT_LO     = 4,
  parameter int CUT_HI     = 8,
  localparam int OP_BITS = ((NUM_INPUTS > 0) ? NUM_INPUTS : 1) * WIDTH
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OP_BITS-1:0] opsIn,
  input  logic [1:0]         partEn,
  output logic [WIDTH-1:0]   sumOut
);
  segCtrl_t segCtrl;

  seg_add_ctrl ctrl_i (.partEn(partEn), .segCtrl(segCtrl));

  seg_add_datapath #(
    .WIDTH(WIDTH), .NUM_INPUTS(NUM_INPUTS), .REG_LEVELS(REG_LEVELS),
    .CUT_LO(CUT_LO), .CUT_HI(CUT_HI)
  ) dp_i (
    .clk(clk), .rstN(rstN), .opsIn(opsIn), .segCtrl(segCtrl), .sumOut(sumOut)
  );
endmodule

// File: rtl/seg_add_tree_chk.sv
module seg_add_tree_chk import seg_add_pkg::*; #(
  parameter int WIDTH      = 16,
  parameter int NUM_INPUTS = 9,
  parameter logic [MASK_BITS-1:0] REG_LEVELS = 8'h15,
  parameter int CUT_LO     = 4,
  parameter int CUT_HI     = 8,
  localparam int OP_BITS = ((NUM_INPUTS > 0) ? NUM_INPUTS : 1) * WIDTH,
  localparam int OPS     = (NUM_INPUTS < 2) ? 2 : NUM_INPUTS,
  localparam int NLEV    = treeDepth(OPS),
  localparam int LAT     = regCount(REG_LEVELS, NLEV),
  localparam int LATX    = (LAT > 0) ? LAT : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [OP_BITS-1:0] opsIn,
  input logic [1:0]         partEn,
  input logic [WIDTH-1:0]   sumOut
);
  // Model: each bit gets a field index from the enables, each field summed alone.
  function automatic logic [WIDTH-1:0] segRef(input logic [OP_BITS-1:0] ops,
                                              input logic [1:0] pe);
    logic [WIDTH-1:0] res, fieldMask, acc;
    res = '0;
    for (int s = 0; s < 3; s++) begin
      fieldMask = '0;
      for (int bt = 0; bt < WIDTH; bt++)
        fieldMask[bt] = (int'(pe[0] && bt >= CUT_LO) + int'(pe[1] && bt >= CUT_HI)) == s;
      acc = '0;
      for (int i = 0; i < NUM_INPUTS; i++) acc = acc + (ops[i*WIDTH +: WIDTH] & fieldMask);
      res = res | (acc & fieldMask);
    end
    return res;
  endfunction

  function automatic logic [CUT_LO-1:0] lowRef(input logic [OP_BITS-1:0] ops);
    logic [CUT_LO-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_INPUTS; i++) acc = acc + ops[i*WIDTH +: CUT_LO];
    return acc;
  endfunction

  logic [WIDTH-1:0]  refNow, refDly;
  logic [CUT_LO-1:0] lowNow, lowDly;
  logic              cutDly;
  logic [WIDTH-1:0]  refPipe [0:LATX-1];
  logic [CUT_LO-1:0] lowPipe [0:LATX-1];
  logic              cutPipe [0:LATX-1];
  logic [OP_BITS+1:0] lastIn;
  int warmCnt, quietCnt;
  logic sameIn;

  assign refNow = segRef(opsIn, partEn);
  assign lowNow = lowRef(opsIn);
  assign sameIn = ({opsIn, partEn} == lastIn);

  always_ff @(posedge clk) begin
    refPipe[0] <= refNow;
    lowPipe[0] <= lowNow;
    cutPipe[0] <= partEn[0];
    for (int i = 1; i < LATX; i++) begin
      refPipe[i] <= refPipe[i-1];
      lowPipe[i] <= lowPipe[i-1];
      cutPipe[i] <= cutPipe[i-1];
    end
  end

  if (LAT == 0) begin : g_comb
    assign refDly = refNow;
    assign lowDly = lowNow;
    assign cutDly = partEn[0];
  end else begin : g_piped
    assign refDly = refPipe[LAT-1];
    assign lowDly = lowPipe[LAT-1];
    assign cutDly = cutPipe[LAT-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt  <= 0;
      quietCnt <= 0;
      lastIn   <= '0;
    end else begin
      if (warmCnt <= LAT) warmCnt <= warmCnt + 1;
      lastIn <= {opsIn, partEn};
      if (!sameIn)                quietCnt <= 0;
      else if (quietCnt < LAT + 4) quietCnt <= quietCnt + 1;
    end
  end

  // R2, R3 and R4: the output equals the field-wise sum from exactly LAT cycles earlier
  a_r2_seg_sum: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= LAT) |-> (sumOut == refDly));

  a_r3_low_cut: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= LAT && cutDly) |-> (sumOut[CUT_LO-1:0] == lowDly));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt > LAT && quietCnt >= LAT + 2 && sameIn) |-> $stable(sumOut));

  if (NUM_INPUTS == 0) begin : g_empty
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
      (warmCnt >= LAT) |-> (sumOut == '0));
  end
endmodule

bind seg_add_tree seg_add_tree_chk #(
  .WIDTH(WIDTH), .NUM_INPUTS(NUM_INPUTS), .REG_LEVELS(REG_LEVELS),
  .CUT_LO(CUT_LO), .CUT_HI(CUT_HI)
) chk_i (.*);

// File: tb/seg_add_tree_tb_top.sv
module seg_add_tree_tb_top;
  localparam logic [7:0] REG_M = 8'h15;
  localparam logic [7:0] REG_Z = 8'h01;
  localparam logic [7:0] REG_P = 8'h00;
  localparam int LATM = $countones(REG_M);
  localparam int LATZ = $countones(REG_Z);
  localparam int LATP = $countones(REG_P);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [143:0] opsIn = '0;
  logic [1:0] partEn = 2'b00;
  logic [15:0] sumMain, sumZero, sumPair;
  int checks = 0;
  int errors = 0;
  int nDrv = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;
  logic [15:0] histM [0:15];
  logic [15:0] histP [0:15];
  string reqH [0:15];

  always #4 clk = ~clk;

  seg_add_tree #(.WIDTH(16), .NUM_INPUTS(9), .REG_LEVELS(REG_M)) dut_i (
    .clk(clk), .rstN(rstN), .opsIn(opsIn), .partEn(partEn), .sumOut(sumMain));
  seg_add_tree #(.WIDTH(16), .NUM_INPUTS(0), .REG_LEVELS(REG_Z)) dutZero_i (
    .clk(clk), .rstN(rstN), .opsIn(opsIn[15:0]), .partEn(partEn), .sumOut(sumZero));
  seg_add_tree #(.WIDTH(16), .NUM_INPUTS(2), .REG_LEVELS(REG_P)) dutPair_i (
    .clk(clk), .rstN(rstN), .opsIn(opsIn[31:0]), .partEn(partEn), .sumOut(sumPair));

  // Field edges from the enables; each field is summed and wrapped independently.
  function automatic logic [15:0] refModel(input logic [143:0] ops, input int cnt,
                                           input logic [1:0] pe);
    int bounds[4];
    int nb;
    logic [31:0] acc;
    logic [15:0] m, res;
    res = '0;
    bounds[0] = 0;
    nb = 1;
    if (pe[0]) begin bounds[nb] = 4; nb++; end
    if (pe[1]) begin bounds[nb] = 8; nb++; end
    bounds[nb] = 16;
    for (int s = 0; s < nb; s++) begin
      m = 16'((32'd1 << bounds[s+1]) - (32'd1 << bounds[s]));
      acc = '0;
      for (int i = 0; i < cnt; i++) acc = acc + {16'h0, ops[i*16 +: 16] & m};
      res = res | (acc[15:0] & m);
    end
    return res;
  endfunction

  function automatic logic [143:0] fillAll(input logic [15:0] v);
    logic [143:0] o;
    for (int i = 0; i < 9; i++) o[i*16 +: 16] = v;
    return o;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic nextRand(output logic [143:0] o);
    for (int i = 0; i < 9; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      o[i*16 +: 16] = lfsr[23:8];
    end
  endtask

  task automatic drive(input logic [143:0] ops, input logic [1:0] pe, input string req);
    int cur;
    @(negedge clk);
    opsIn = ops;
    partEn = pe;
    cur = nDrv;
    histM[cur % 16] = refModel(ops, 9, pe);
    histP[cur % 16] = refModel(ops, 2, pe);
    reqH[cur % 16] = req;
    nDrv++;
    #1;
    if (cur >= LATM) check(reqH[(cur - LATM) % 16], sumMain, histM[(cur - LATM) % 16]);
    if (cur >= LATP) check("R4 comb pair", sumPair, histP[(cur - LATP) % 16]);
    if (cur >= LATZ) check("R5", sumZero, 16'h0000);
  endtask

  initial begin
    logic [143:0] v;
    logic [15:0] prevSum;
    // R6: reset holds registered stages at zero even with busy inputs
    opsIn = fillAll(16'hFFFF);
    partEn = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    check("R6", sumMain, 16'h0000);
    check("R6", sumZero, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;

    // R2: unsegmented patterns
    drive('0, 2'b00, "R2 zeros");
    drive(fillAll(16'hFFFF), 2'b00, "R2 all ones");
    drive(fillAll(16'h8000), 2'b00, "R2 top bit");
    for (int i = 0; i < 9; i++) v[i*16 +: 16] = 16'(i * 16'h1111 + 1);
    drive(v, 2'b00, "R2 ramp");
    for (int b = 0; b < 16; b++) drive(fillAll(16'h0001 << b), 2'b00, "R2 walking one");

    // R1: a single operand at the top and bottom positions
    v = '0; v[8*16 +: 16] = 16'h1234;
    drive(v, 2'b00, "R1 last operand");
    v = '0; v[15:0] = 16'h00A5;
    drive(v, 2'b00, "R1 first operand");
    v = '0; v[16 +: 16] = 16'h5A00;
    drive(v, 2'b11, "R1 second operand");

    // R3: carries aimed at each break point, then pseudo-random fill
    for (int pe = 1; pe < 4; pe++) begin
      drive(fillAll(16'hFFFF), 2'(pe), "R3 all ones");
      drive(fillAll(16'h000F), 2'(pe), "R3 low nibble carry");
      drive(fillAll(16'h00FF), 2'(pe), "R3 byte carry");
      drive(fillAll(16'h0F0F), 2'(pe), "R3 mid carry");
      for (int j = 0; j < 40; j++) begin
        nextRand(v);
        drive(v, 2'(pe), "R3 random");
      end
    end
    for (int j = 0; j < 40; j++) begin
      nextRand(v);
      drive(v, 2'b00, "R2 random");
    end

    // R4: enables change every cycle and must stay aligned with their operands
    for (int j = 0; j < 300; j++) begin
      nextRand(v);
      drive(v, 2'(lfsr[3:2]), "R4 streaming");
    end

    // R7: held input keeps the output steady
    nextRand(v);
    prevSum = '0;
    for (int j = 0; j < 8; j++) begin
      drive(v, 2'b10, "R7 hold");
      if (j > LATM) check("R7", sumMain, prevSum);
      prevSum = sumMain;
    end

    for (int j = 0; j < LATM + 1; j++) drive('0, 2'b00, "R2 drain");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule